// File: doc/BRIEF.md
# Channel Status Frame Sequencer

This block feeds the channel-status stream of a consumer digital audio transmitter. It takes a block of status information as six 32-bit words. Together they form the 192 bits carried one per frame. A serializer pulses a frame strobe once per frame. At each strobe the sequencer presents the next status bit to the subframe builder. It walks word A first and word F last, and within each word it starts at the least significant bit.

Two enables control the block: a transmit enable and a channel-status enable. A block starts only at a frame strobe that finds the sequencer idle with both enables high. At that strobe word A is loaded into an internal shifter and `busy` rises. `busy` drops on the strobe that loads word F. From then on the six word inputs may be rewritten for the next block while the bits of F are still shifted out. `busy` also drops on the first strobe after the transmit enable has gone low, and that strobe ends the sequence. At the end of a block the sequence starts again from word A if both enables are still high. Biphase coding and preambles are handled elsewhere.

Top module: `cs_frame_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0 and `cs_bit` is 0.
- R2: A frame strobe that finds the sequencer idle with `tx_en` and `cs_en` both high loads word A. `busy` is 1 after that edge, and `cs_bit` shows bit 0 of word A. A strobe that finds the sequencer idle with either enable low leaves it idle.
- R3: Each later strobe moves one bit further, least significant bit first. Words run A through F, with word A at `cs_words[31:0]` and word F at `cs_words[191:160]`. Frame k of a block (k = 0 to 191) carries bit k mod 32 of word k/32.
- R4: `busy` stays 1 through frames 0 to 159. It falls on the strobe that loads word F (frame 160). The 32 bits of word F are still delivered after that.
- R5: At a strobe where `tx_en` is low, an active sequencer returns to idle, and `busy` and `cs_bit` become 0. Before that strobe, `busy` keeps its value even though `tx_en` is already low.
- R6: While `cs_en` is low, `cs_bit` is 0. The position within the block still advances at each strobe, so the correct bit appears again once `cs_en` returns.
- R7: At the strobe after frame 191, the sequence restarts with word A (frame 0, `busy` 1) if both enables are high. Otherwise the sequencer goes idle.
- R8: Without a frame strobe, `busy` and the sequence state do not change.
- R9: A word is captured when it is loaded. Rewriting the word now being shifted has no effect on the stream. Rewriting a word that has not yet been loaded does take effect.
- R10: `cs_bit` is 0 whenever the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| cs_en | input | 1 | Channel-status insertion enable |
| frame_strobe | input | 1 | One-cycle pulse at each frame boundary |
| cs_words | input | 192 | Six status words, A in the lowest 32 bits, F in the highest |
| cs_bit | output | 1 | Status bit for the current frame |
| busy | output | 1 | Status words A to E still in use |

## Verification
Two decisions can fall on the same strobe, and the bench provokes both. The first is the end of a block. The strobe that completes frame 191 must choose between a restart and going idle. The bench drives it once with both enables high and a freshly rewritten word A, which must appear at frame 0. It drives it once with `cs_en` low, which must leave `busy` and `cs_bit` at 0. The second is a rewrite of the word inputs while a word is being shifted. The bench rewrites the word in the shifter and a later word in the same frame, and judges the result bit by bit against an expected table held in the bench.

// File: rtl/csq_pkg.sv
// Package: shared defaults and the sequencer state type.
// Assumes: nothing beyond IEEE 1800-2017.
package csq_pkg;
    localparam int CS_WORD_W  = 32;
    localparam int CS_N_WORDS = 6;

    // IDLE: nothing shifting; HELD: words in use; TAIL: last word shifting, words released
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HELD = 2'd1,
        SEQ_TAIL = 2'd2
    } seq_state_e;
endpackage

// File: rtl/csq_word_mux.sv
// Module: selects one status word from the flat word bus.
// Assumes: word 0 sits in the lowest WORD_W bits; out-of-range select gives zero.
module csq_word_mux #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 6,
    parameter int IDX_W   = 3
) (
    input  logic [N_WORDS*WORD_W-1:0] words_flat,
    input  logic [IDX_W-1:0]          sel,
    output logic [WORD_W-1:0]         word
);
    logic [WORD_W-1:0] word_arr [N_WORDS];

    // unpack the flat bus into an array of words
    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_unpack
        assign word_arr[gi] = words_flat[gi*WORD_W +: WORD_W];
    end

    // pick the addressed word
    always_comb begin
        word = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (sel == IDX_W'(i)) word = word_arr[i];
        end
    end
endmodule

// File: rtl/csq_shifter.sv
// Module: holds the word being sent and shifts it right one place per frame.
// Assumes: load, shift and clear come from the controller, at most one has effect, clear wins.
module csq_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              clear,
    input  logic [WORD_W-1:0] load_val,
    output logic              lsb
);
    logic [WORD_W-1:0] sh_q;

    // capture, shift right or empty the word register
    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= '0;
        else if (clear)  sh_q <= '0;
        else if (load)   sh_q <= load_val;
        else if (shift)  sh_q <= {1'b0, sh_q[WORD_W-1:1]};
    end

    assign lsb = sh_q[0];
endmodule

// File: rtl/csq_ctrl.sv
// Module: bit and word position counters and the busy state machine.
// Assumes: N_WORDS >= 2, frame_strobe is a single-cycle pulse, enables sampled at strobes only.
module csq_ctrl
    import csq_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 6,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic             tx_en,
    input  logic             cs_en,
    output logic             load,
    output logic             shift,
    output logic             clear,
    output logic [IDX_W-1:0] word_sel,
    output logic             busy,
    output logic             active
);
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(N_WORDS - 1);

    seq_state_e       state_q, state_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic [IDX_W-1:0] word_q, word_d;
    logic             word_end, block_end;
    logic [IDX_W-1:0] word_nx;

    assign word_end  = (bit_q == LAST_BIT);
    assign block_end = word_end && (word_q == LAST_WORD);
    assign word_nx   = word_q + IDX_W'(1);

    // decide the next position and the shifter command at each frame strobe
    always_comb begin
        state_d  = state_q;
        bit_d    = bit_q;
        word_d   = word_q;
        load     = 1'b0;
        shift    = 1'b0;
        clear    = 1'b0;
        word_sel = word_q;
        if (frame_strobe) begin
            case (state_q)
                SEQ_IDLE: begin
                    if (tx_en && cs_en) begin
                        load     = 1'b1;
                        word_sel = '0;
                        bit_d    = '0;
                        word_d   = '0;
                        state_d  = SEQ_HELD;
                    end
                end
                default: begin
                    if (!tx_en) begin
                        clear   = 1'b1;
                        bit_d   = '0;
                        word_d  = '0;
                        state_d = SEQ_IDLE;
                    end else if (!word_end) begin
                        shift = 1'b1;
                        bit_d = bit_q + BIT_W'(1);
                    end else if (!block_end) begin
                        load     = 1'b1;
                        word_sel = word_nx;
                        word_d   = word_nx;
                        bit_d    = '0;
                        state_d  = (word_nx == LAST_WORD) ? SEQ_TAIL : state_q;
                    end else if (cs_en) begin
                        load     = 1'b1;
                        word_sel = '0;
                        word_d   = '0;
                        bit_d    = '0;
                        state_d  = SEQ_HELD;
                    end else begin
                        clear   = 1'b1;
                        bit_d   = '0;
                        word_d  = '0;
                        state_d = SEQ_IDLE;
                    end
                end
            endcase
        end
    end

    // register the state and position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            bit_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            word_q  <= word_d;
        end
    end

    assign busy   = (state_q == SEQ_HELD);
    assign active = (state_q != SEQ_IDLE);
endmodule

// File: rtl/cs_frame_seq.sv
// Module: channel status frame sequencer top; one status bit per frame strobe.
// Assumes: N_WORDS >= 2; word A occupies the lowest WORD_W bits of cs_words.
module cs_frame_seq #(
    parameter int WORD_W  = csq_pkg::CS_WORD_W,
    parameter int N_WORDS = csq_pkg::CS_N_WORDS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tx_en,
    input  logic                      cs_en,
    input  logic                      frame_strobe,
    input  logic [N_WORDS*WORD_W-1:0] cs_words,
    output logic                      cs_bit,
    output logic                      busy
);
    localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic             ld, sh, clr, sh_lsb, seq_active;
    logic [IDX_W-1:0] sel;
    logic [WORD_W-1:0] sel_word;

    csq_ctrl #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .tx_en(tx_en), .cs_en(cs_en), .load(ld), .shift(sh), .clear(clr),
        .word_sel(sel), .busy(busy), .active(seq_active)
    );

    csq_word_mux #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_mux (
        .words_flat(cs_words), .sel(sel), .word(sel_word)
    );

    csq_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(ld), .shift(sh), .clear(clr),
        .load_val(sel_word), .lsb(sh_lsb)
    );

    // present the bit only while a block is running and insertion is enabled
    assign cs_bit = seq_active && cs_en && sh_lsb;
endmodule

// File: rtl/csq_checker.sv
// Module: temporal checks on the sequencer, bound to the top module.
// Assumes: active is the top's internal running indication.
module csq_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_strobe,
    input logic tx_en,
    input logic cs_en,
    input logic busy,
    input logic active,
    input logic cs_bit
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !active && tx_en && cs_en) |=> busy);

    assert_nostart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !active && !(tx_en && cs_en)) |=> !active);

    assert_busy_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> active);

    assert_txoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && active && !tx_en) |=> (!active && !busy));

    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_en |-> !cs_bit);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> ($stable(busy) && $stable(active)));

    assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(frame_strobe));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !cs_bit);
endmodule

bind cs_frame_seq csq_checker u_csq_chk (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .tx_en(tx_en),
    .cs_en(cs_en), .busy(busy), .active(seq_active), .cs_bit(cs_bit)
);

// File: tb/sim_cs_frame_seq.sv
module sim_cs_frame_seq;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int NW = 6;
    localparam int FRAMES = W * NW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic cs_en = 1'b0;
    logic frame_strobe = 1'b0;
    logic [NW*W-1:0] cs_words;
    logic cs_bit, busy;

    logic [W-1:0] w [NW];
    logic [W-1:0] e [NW];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NW; i++) cs_words[i*W +: W] = w[i];
    end

    cs_frame_seq u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en),
        .frame_strobe(frame_strobe), .cs_words(cs_words),
        .cs_bit(cs_bit), .busy(busy)
    );

    function automatic logic [W-1:0] pat(int seed, int i);
        return (32'h9E3779B9 * (i + 1 + seed * 7)) ^ {seed[15:0], 16'h5AC3};
    endfunction

    task automatic load_words(int seed);
        for (int i = 0; i < NW; i++) begin
            w[i] = pat(seed, i);
            e[i] = pat(seed, i);
        end
    endtask

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
    endtask

    // one frame of a running block: expected bit from table, busy from frame index
    task automatic step(int k, string tag);
        logic eb;
        pulse();
        eb = cs_en ? e[k / W][k % W] : 1'b0;
        chk({tag, " bit"}, W'(cs_bit), W'(eb));
        chk({tag, " busy"}, W'(busy), W'(k < (NW - 1) * W));
    endtask

    initial begin
        logic hb, hz;
        load_words(1);
        repeat (3) @(negedge clk);
        chk("R1 busy", W'(busy), 0);
        chk("R1 bit", W'(cs_bit), 0);
        @(negedge clk) rst_n = 1'b1;

        // no start with one enable low
        tx_en = 1'b1; cs_en = 1'b0;
        pulse();
        chk("R2 no start cs off", W'(busy), 0);
        chk("R10 idle bit", W'(cs_bit), 0);
        tx_en = 1'b0; cs_en = 1'b1;
        pulse();
        chk("R2 no start tx off", W'(busy), 0);
        chk("R10 idle bit tx off", W'(cs_bit), 0);

        // block 1: full walk with rewrites, gating and a hold check
        tx_en = 1'b1;
        for (int k = 0; k < FRAMES; k++) begin
            if (k == 60) cs_en = 1'b0;
            if (k == 70) cs_en = 1'b1;
            step(k, (k == 0) ? "R2 start" : (k >= 60 && k < 70) ? "R6 gated" :
                    (k == 160) ? "R4 F load" : "R3 walk");
            if (k == 10) begin
                w[0] = ~w[0];
                w[2] = pat(9, 2);
                e[2] = pat(9, 2);
            end
            if (k == 40) begin
                hb = cs_bit; hz = busy;
                @(negedge clk);
                chk("R8 hold bit", W'(cs_bit), W'(hb));
                chk("R8 hold busy", W'(busy), W'(hz));
            end
            if (k == 170) begin
                w[0] = 32'h0F0F_3C3C;
                e[0] = 32'h0F0F_3C3C;
            end
        end
        // block 2: restart with rewritten word A
        for (int k = 0; k < FRAMES; k++) begin
            step(k, (k == 0) ? "R7 restart R9" : "R3 walk2");
        end
        // block end with cs_en low: go idle
        cs_en = 1'b0;
        pulse();
        chk("R7 end idle busy", W'(busy), 0);
        chk("R7 end idle bit", W'(cs_bit), 0);
        pulse();
        chk("R2 stay idle", W'(busy), 0);

        // block 3: tx_en drop mid-block
        cs_en = 1'b1;
        load_words(3);
        for (int k = 0; k < 51; k++) step(k, "R3 walk3");
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        chk("R5 busy held until strobe", W'(busy), 1);
        pulse();
        chk("R5 stop busy", W'(busy), 0);
        chk("R5 stop bit", W'(cs_bit), 0);
        pulse();
        chk("R10 idle after stop", W'(cs_bit), 0);

        // block 4: tx_en drop during the last word
        tx_en = 1'b1;
        load_words(4);
        for (int k = 0; k < 176; k++) step(k, (k == 0) ? "R2 start4" : "R4 tail");
        tx_en = 1'b0;
        pulse();
        chk("R5 tail stop busy", W'(busy), 0);
        chk("R5 tail stop bit", W'(cs_bit), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule